// File: doc/BRIEF.md
# Byte-Lane Comma Word Aligner

This block sits behind a multi-lane serial receiver that delivers a word of several bytes per clock, with one control-character flag per byte. The receiver has no fixed relationship between the start of a frame and a byte lane. The block searches each incoming word for a control byte of value 0x81 and stores the lane where it was found as the alignment offset. From then on it rebuilds every output word so that the marker byte, and each byte after it, sits in its proper lane. Lane 0 holds the marker.

Each output word is cut from a window of two consecutive input words. The older word forms the low lanes of the window and the newer word forms the high lanes. The stored offset picks the first window lane of the output. The control flags are cut from the same window at the same offset, so each flag stays with its byte. By default the output stage is registered. A build-time parameter can make that stage combinational instead, which removes one cycle of latency but lengthens the path from input to output.

Top module: `comma_word_aligner`

## Requirements
- R1: Lane i (byte bits [8i+7:8i], flag bit i) is a marker only when ctrl_i[i] is 1 and its byte equals 0x81. A marker byte with its flag clear, or a flagged byte of any other value, is ignored.
- R2: When several lanes of one word hold a marker, the lowest-numbered lane becomes the offset.
- R3: A word without a marker leaves the stored offset unchanged and produces aligned_o low for that word.
- R4: Output lane j carries window lane (offset + j). Window lanes 0 to LANES-1 are the older input word and lanes LANES to 2*LANES-1 are the newer one.
- R5: ctrl_o is cut from the same two words at the same offset as data_o, so flag j belongs to output byte j.
- R6: With REG_OUT=1, if a word holding a marker at lane k is sampled at clock edge e, then after edge e+1 data_o lane 0 equals 0x81, ctrl_o[0] is 1 and aligned_o is 1. With REG_OUT=0, the same result appears one edge earlier.
- R7: While rst_ni is low, data_o, ctrl_o and aligned_o are 0, the offset is 0 and the word history is 0.
- R8: After a marker is found, later words that hold no marker keep being realigned with the same offset, and aligned_o returns to 0 one word later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8*LANES | Raw receive word |
| ctrl_i | input | LANES | Per-byte control-character flags |
| data_o | output | 8*LANES | Realigned word |
| ctrl_o | output | LANES | Realigned control flags |
| aligned_o | output | 1 | Marker found in the word now forming the low half of the output |

## Verification
The bench uses the default registered build. In that build, a word sampled at edge e sets the offset and the aligned state at that edge. The output word cut from it, together with its aligned flag, is visible after edge e+1. The driver computes this expected output from its own model of the window and the offset when it presents the word one half cycle before edge e+1. The monitor then compares data_o, ctrl_o and aligned_o 1 ns after that edge, so each expectation is checked exactly once, in the cycle it falls due.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MARKER_DEFAULT = 8'h81;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/comma_lane_finder.sv
module comma_lane_finder
  import comma_align_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter byte_t       MARKER = MARKER_DEFAULT,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [BYTE_W*LANES-1:0] data_i,
  input  logic [LANES-1:0]        ctrl_i,
  output logic [LANES-1:0]        match_o,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_cmp
    assign match_o[g] = ctrl_i[g] && (data_i[g*BYTE_W +: BYTE_W] == MARKER);
  end

  // scan high to low so the lowest matching lane is written last
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (match_o[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  a_r1_hit_lane_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_o[idx_o]);

  a_r2_lowest_lane_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_o & ((LANES'(1) << idx_o) - LANES'(1))) == '0));

  a_r1_no_hit_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (match_o == '0));

endmodule

// File: rtl/word_history.sv
module word_history #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

endmodule

// File: rtl/lane_window_mux.sv
module lane_window_mux #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned WIN_N = 2 * LANES
) (
  input  logic [LANE_W*LANES-1:0] new_i,
  input  logic [LANE_W*LANES-1:0] old_i,
  input  logic [IDX_W-1:0]        sel_i,
  output logic [LANE_W*LANES-1:0] out_o
);

  logic [WIN_N-1:0][LANE_W-1:0] win;

  // older word occupies the low lanes of the window
  assign win = {new_i, old_i};

  for (genvar j = 0; j < LANES; j++) begin : g_out_lane
    logic [IDX_W:0] pos;
    assign pos = {1'b0, sel_i} + (IDX_W + 1)'(j);
    assign out_o[j*LANE_W +: LANE_W] = win[pos];
  end

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import comma_align_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter byte_t       MARKER  = MARKER_DEFAULT,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned DW     = BYTE_W * LANES,
  localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    data_i,
  input  logic [LANES-1:0] ctrl_i,
  output logic [DW-1:0]    data_o,
  output logic [LANES-1:0] ctrl_o,
  output logic             aligned_o
);

  logic [LANES-1:0] match;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] off_q;
  logic             found_q;
  logic [DW-1:0]    data_prev;
  logic [LANES-1:0] ctrl_prev;
  logic [DW-1:0]    data_sel;
  logic [LANES-1:0] ctrl_sel;

  comma_lane_finder #(.LANES(LANES), .MARKER(MARKER)) u_finder (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .ctrl_i (ctrl_i),
    .match_o(match),
    .hit_o  (hit),
    .idx_o  (hit_idx)
  );

  word_history #(.W(DW)) u_data_hist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (data_i),
    .q_o   (data_prev)
  );

  word_history #(.W(LANES)) u_ctrl_hist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctrl_i),
    .q_o   (ctrl_prev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q   <= '0;
      found_q <= 1'b0;
    end else begin
      found_q <= hit;
      if (hit) off_q <= hit_idx;
    end
  end

  lane_window_mux #(.LANES(LANES), .LANE_W(BYTE_W)) u_data_mux (
    .new_i(data_i),
    .old_i(data_prev),
    .sel_i(off_q),
    .out_o(data_sel)
  );

  lane_window_mux #(.LANES(LANES), .LANE_W(1)) u_ctrl_mux (
    .new_i(ctrl_i),
    .old_i(ctrl_prev),
    .sel_i(off_q),
    .out_o(ctrl_sel)
  );

  if (REG_OUT) begin : g_reg_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o    <= '0;
        ctrl_o    <= '0;
        aligned_o <= 1'b0;
      end else begin
        data_o    <= data_sel;
        ctrl_o    <= ctrl_sel;
        aligned_o <= found_q;
      end
    end

    a_r6_aligned_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      found_q |=> aligned_o);

    a_r4_marker_in_lane0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      found_q |=> (data_o[BYTE_W-1:0] == MARKER) && ctrl_o[0]);
  end else begin : g_comb_out
    assign data_o    = data_sel;
    assign ctrl_o    = ctrl_sel;
    assign aligned_o = found_q;

    a_r4_marker_in_lane0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      aligned_o |-> (data_o[BYTE_W-1:0] == MARKER) && ctrl_o[0]);
  end

  a_r3_offset_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(off_q));

  a_r3_no_hit_not_found: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> !found_q);

endmodule

// File: tb/comma_word_aligner_tb.sv
module comma_word_aligner_tb;
  localparam int L  = 4;
  localparam int DW = 8 * L;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [L-1:0]  ctrl_i = '0;
  logic [DW-1:0] data_o;
  logic [L-1:0]  ctrl_o;
  logic          aligned_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [DW-1:0] exp_d_q[$];
  logic [L-1:0]  exp_c_q[$];
  logic          exp_a_q[$];
  string         tag_q[$];

  logic [DW-1:0] m_prev_d = '0;
  logic [L-1:0]  m_prev_c = '0;
  int            m_off = 0;
  logic          m_al = 1'b0;

  comma_word_aligner #(.LANES(L)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .ctrl_i(ctrl_i),
    .data_o(data_o), .ctrl_o(ctrl_o), .aligned_o(aligned_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: present a word and push what the output must be after the edge
  task automatic drive(input logic [DW-1:0] d, input logic [L-1:0] c, input string tag);
    logic [2*DW-1:0] wd;
    logic [2*L-1:0]  wc;
    bit found;
    int idx;
    @(negedge clk_i);
    data_i = d;
    ctrl_i = c;
    wd = {d, m_prev_d} >> (m_off * 8);
    wc = {c, m_prev_c} >> m_off;
    exp_d_q.push_back(wd[DW-1:0]);
    exp_c_q.push_back(wc[L-1:0]);
    exp_a_q.push_back(m_al);
    tag_q.push_back(tag);
    found = 1'b0;
    idx = 0;
    for (int i = 0; i < L; i++)
      if (!found && c[i] && d[8*i +: 8] == 8'h81) begin
        found = 1'b1;
        idx = i;
      end
    m_prev_d = d;
    m_prev_c = c;
    m_al = found;
    if (found) m_off = idx;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_d_q.size() > 0) begin
        string t;
        t = tag_q.pop_front();
        check({t, " data"}, data_o, exp_d_q.pop_front());
        check({t, " ctrl"}, DW'(ctrl_o), DW'(exp_c_q.pop_front()));
        check({t, " aligned"}, DW'(aligned_o), DW'(exp_a_q.pop_front()));
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R7 reset data", data_o, '0);
    check("R7 reset ctrl", DW'(ctrl_o), '0);
    check("R7 reset aligned", DW'(aligned_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    drive(32'h0403_0201, 4'h0, "R3 idle");
    drive(32'h0807_0605, 4'h0, "R3 idle");
    drive(32'h0C0B_0A09, 4'h0, "R4 offset0");
    // marker at lane 2
    drive(32'h1181_1010, 4'b0100, "R1 lane2");
    drive(32'h1514_1312, 4'h0, "R6 lane2");
    drive(32'h1918_1716, 4'h0, "R8 hold");
    drive(32'h1D1C_1B1A, 4'h0, "R8 hold");
    // 0x81 without flag, flagged non-marker: ignored
    drive(32'h2020_8120, 4'h0, "R1 unflagged");
    drive(32'h2121_2121, 4'b0010, "R1 wrong byte");
    drive(32'h2322_2120, 4'h0, "R3 keep offset");
    drive(32'h2726_2524, 4'h0, "R3 keep offset");
    // two markers: lanes 1 and 3
    drive(32'h8130_8130, 4'b1010, "R2 lowest");
    drive(32'h3433_3231, 4'b0001, "R5 ctrl follow");
    drive(32'h3837_3635, 4'b0100, "R5 ctrl follow");
    // lane 3, then lane 0
    drive(32'h8140_4040, 4'b1000, "R4 lane3");
    drive(32'h4443_4241, 4'b0010, "R4 lane3");
    drive(32'h5050_5081, 4'b0001, "R4 lane0");
    drive(32'h5453_5251, 4'h0, "R6 lane0");
    drive(32'h5857_5655, 4'h0, "R8 hold");
    for (int k = 0; k < 60; k++) begin
      logic [DW-1:0] d;
      logic [L-1:0]  c;
      d = $urandom;
      c = L'($urandom);
      if (k % 7 == 3) begin
        d[8*(k%4) +: 8] = 8'h81;
        c[k%4] = 1'b1;
      end
      drive(d, c, "R4 mixed");
    end
    drive(32'h0, 4'h0, "R8 drain");
    @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule